// File: doc/BRIEF.md
# Shift-Register Sequenced Instruction Address Unit

This unit produces the instruction fetch address for a small 4-bit controller. The in-page program counter is 6 bits wide. It does not count. Each step moves it to the next state of a maximal-length shift-register sequence, so instructions that follow each other sit at scattered ROM locations. The upper part of the address comes from a 4-bit page register and an optional 1-bit chapter register.

The unit has no stack. Subroutine linkage uses two shadow registers: a page buffer and a return register. A taken call swaps the page with the page buffer and saves the successor address in the return register. A return swaps them back. Only one subroutine level exists.

Taken branches and calls depend on a 1-bit status flag. The instruction decoder raises the request lines and pulses the advance strobe once per instruction.

Top module: `lfsr_pc_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first advance, `addr_o` is 0 and `in_sub_o` is 0.
- R2: A plain step (advance with no branch, call or return request) replaces the counter p with {p[4:0], f}, where f = NOT(p[5] XOR p[4]) XOR AND(p[4:0]). The page and chapter do not change. Starting from 0, the counter visits all 64 values and returns to 0 after 64 steps.
- R3: While `adv_i` is low, the address and the subroutine flag hold, whatever the request lines carry.
- R4: A branch request with status 1, outside subroutine mode, loads the counter with `target_i`, the page with the page buffer and the chapter with the chapter buffer. With status 0, the branch request only steps the counter.
- R5: A taken branch in subroutine mode loads the counter with `target_i` and leaves the page and chapter unchanged.
- R6: A call request with status 1, outside subroutine mode, does all of the following:
  - loads the counter with `target_i`;
  - exchanges the page with the page buffer;
  - stores the counter's successor in the return register;
  - sets subroutine mode.

  With status 0, the call request only steps the counter.
- R7: A call request in subroutine mode is not taken. The counter steps, and the page and the subroutine flag stay as they are.
- R8: A return request in subroutine mode does all of the following:
  - loads the counter from the return register;
  - exchanges the page with the page buffer;
  - clears subroutine mode.

  Outside subroutine mode, a return request only steps the counter. When several requests arrive together, return outranks call and call outranks branch.
- R9: `pbuf_ld_i` (advance not needed) writes `pbuf_val_i` into the page buffer and `chap_val_i` into the chapter buffer. If a call or return exchange happens in the same cycle, the exchange wins and the load is dropped.
- R10: `addr_o` is {chapter, page, counter}: bit 10 is the chapter, bits 9:6 the page, and bits 5:0 the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance strobe, one per instruction |
| branch_i | input | 1 | Branch request |
| call_i | input | 1 | Call request |
| ret_i | input | 1 | Return request |
| status_i | input | 1 | Condition flag for branch and call |
| target_i | input | 6 | In-page destination |
| pbuf_ld_i | input | 1 | Page and chapter buffer load |
| pbuf_val_i | input | 4 | Page buffer value |
| chap_val_i | input | 1 | Chapter buffer value |
| addr_o | output | 11 | ROM address |
| in_sub_o | output | 1 | Subroutine mode flag |

## Verification
Every state change takes effect at the rising edge that samples the advance strobe. The new address and the new subroutine flag are therefore due one cycle after the stimulus.

The bench drives inputs on the falling edge and updates its behavioural model at the next rising edge. It compares `addr_o` and `in_sub_o` on the falling edge that follows.

A buffer load cannot be seen directly at the ports. The bench checks it through the page and chapter that a later taken branch or call brings out.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_JUMP,
    OP_CALL,
    OP_RET
  } pcu_op_e;
endpackage

// File: rtl/pcu_op_sel.sv
module pcu_op_sel
  import pcu_pkg::*;
(
  input  logic    adv_i,
  input  logic    branch_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    status_i,
  input  logic    in_sub_i,
  output pcu_op_e op_o
);
  // priority: return, call, branch
  always_comb begin
    if (!adv_i)        op_o = OP_HOLD;
    else if (ret_i)    op_o = in_sub_i ? OP_RET : OP_STEP;
    else if (call_i)   op_o = (status_i && !in_sub_i) ? OP_CALL : OP_STEP;
    else if (branch_i) op_o = status_i ? OP_JUMP : OP_STEP;
    else               op_o = OP_STEP;
  end
endmodule

// File: rtl/pcu_lfsr_step.sv
module pcu_lfsr_step #(
  parameter int W     = 6,
  parameter int TAP_B = 4
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  logic fb;
  // xnor feedback; inverting it when the low W-1 bits are all ones splices the all-ones state in
  always_comb begin
    fb    = ~(cur_i[W-1] ^ cur_i[TAP_B]) ^ (&cur_i[W-2:0]);
    nxt_o = {cur_i[W-2:0], fb};
  end
endmodule

// File: rtl/pcu_page_ctl.sv
module pcu_page_ctl
  import pcu_pkg::*;
#(
  parameter int  PAGE_W      = 4,
  parameter bit  HAS_CHAPTER = 1'b1,
  localparam int CHAP_W      = HAS_CHAPTER ? 1 : 0,
  localparam int HI_W        = PAGE_W + CHAP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pcu_op_e           op_i,
  input  logic              in_sub_i,
  input  logic              ld_i,
  input  logic [PAGE_W-1:0] pbuf_val_i,
  input  logic              chap_val_i,
  output logic [HI_W-1:0]   hi_o
);
  logic [PAGE_W-1:0] page_q, pbuf_q;
  logic              swap, jump_far;

  assign swap     = (op_i == OP_CALL) || (op_i == OP_RET);
  assign jump_far = (op_i == OP_JUMP) && !in_sub_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      pbuf_q <= '0;
    end else if (swap) begin
      page_q <= pbuf_q;
      pbuf_q <= page_q;
    end else begin
      if (jump_far) page_q <= pbuf_q;
      if (ld_i)     pbuf_q <= pbuf_val_i;
    end
  end

  generate
    if (HAS_CHAPTER) begin : g_chap
      logic chap_q, cbuf_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chap_q <= 1'b0;
          cbuf_q <= 1'b0;
        end else begin
          if (jump_far)      chap_q <= cbuf_q;
          if (ld_i && !swap) cbuf_q <= chap_val_i;
        end
      end
      assign hi_o = {chap_q, page_q};
    end else begin : g_nochap
      logic unused_chap;
      assign unused_chap = chap_val_i;
      assign hi_o        = page_q;
    end
  endgenerate
endmodule

// File: rtl/lfsr_pc_unit.sv
module lfsr_pc_unit
  import pcu_pkg::*;
#(
  parameter int  PC_W        = 6,
  parameter int  PC_TAP      = 4,
  parameter int  PAGE_W      = 4,
  parameter bit  HAS_CHAPTER = 1'b1,
  localparam int ADDR_W      = PC_W + PAGE_W + (HAS_CHAPTER ? 1 : 0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              branch_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              status_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic              pbuf_ld_i,
  input  logic [PAGE_W-1:0] pbuf_val_i,
  input  logic              chap_val_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_sub_o
);
  localparam int HI_W = ADDR_W - PC_W;

  pcu_op_e         op;
  logic [PC_W-1:0] pc_q, pc_nxt, ret_q;
  logic            sub_q;
  logic [HI_W-1:0] hi;

  pcu_op_sel u_sel (
    .adv_i   (adv_i),
    .branch_i(branch_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .status_i(status_i),
    .in_sub_i(sub_q),
    .op_o    (op)
  );

  pcu_lfsr_step #(.W(PC_W), .TAP_B(PC_TAP)) u_step (
    .cur_i(pc_q),
    .nxt_o(pc_nxt)
  );

  pcu_page_ctl #(.PAGE_W(PAGE_W), .HAS_CHAPTER(HAS_CHAPTER)) u_page (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .in_sub_i  (sub_q),
    .ld_i      (pbuf_ld_i),
    .pbuf_val_i(pbuf_val_i),
    .chap_val_i(chap_val_i),
    .hi_o      (hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ret_q <= '0;
      sub_q <= 1'b0;
    end else begin
      unique case (op)
        OP_STEP: pc_q <= pc_nxt;
        OP_JUMP: pc_q <= target_i;
        OP_CALL: begin
          pc_q  <= target_i;
          ret_q <= pc_nxt;
          sub_q <= 1'b1;
        end
        OP_RET: begin
          pc_q  <= ret_q;
          sub_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign addr_o   = {hi, pc_q};
  assign in_sub_o = sub_q;
endmodule

// File: rtl/lfsr_pc_unit_chk.sv
module lfsr_pc_unit_chk #(
  parameter int PC_W   = 6,
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adv_i,
  input logic              branch_i,
  input logic              call_i,
  input logic              ret_i,
  input logic              status_i,
  input logic [PC_W-1:0]   target_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              in_sub_o
);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(addr_o) && $stable(in_sub_o));

  a_r2_step_keeps_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ret_i && !call_i && !branch_i |=> $stable(addr_o[ADDR_W-1:PC_W]));

  a_r4_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ret_i && !call_i && branch_i && status_i
      |=> addr_o[PC_W-1:0] == $past(target_i));

  a_r5_sub_jump_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ret_i && !call_i && branch_i && status_i && in_sub_o
      |=> $stable(addr_o[ADDR_W-1:PC_W]));

  a_r6_call_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ret_i && call_i && status_i && !in_sub_o
      |=> in_sub_o && addr_o[PC_W-1:0] == $past(target_i));

  a_r7_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ret_i && call_i && in_sub_o
      |=> in_sub_o && $stable(addr_o[ADDR_W-1:PC_W]));

  a_r8_ret_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && ret_i |=> !in_sub_o);
endmodule

bind lfsr_pc_unit lfsr_pc_unit_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .adv_i   (adv_i),
  .branch_i(branch_i),
  .call_i  (call_i),
  .ret_i   (ret_i),
  .status_i(status_i),
  .target_i(target_i),
  .addr_o  (addr_o),
  .in_sub_o(in_sub_o)
);

// File: tb/sim_lfsr_pc_unit.sv
`timescale 1ns/1ps
module sim_lfsr_pc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        adv_i = 0, branch_i = 0, call_i = 0, ret_i = 0, status_i = 0;
  logic [5:0]  target_i = '0;
  logic        pbuf_ld_i = 0;
  logic [3:0]  pbuf_val_i = '0;
  logic        chap_val_i = 0;
  logic [10:0] addr_o;
  logic        in_sub_o;

  int total = 0, bad = 0;
  bit done = 0;
  int m_pc, m_page, m_pbuf, m_chap, m_cbuf, m_ret, m_sub;

  always #2.5 clk_i = ~clk_i;

  lfsr_pc_unit u0 (.*);

  function automatic int succ(int p);
    int f;
    f = (((p >> 5) & 1) == ((p >> 4) & 1)) ? 1 : 0;
    if ((p & 31) == 31) f = 1 - f;
    return ((p << 1) & 63) | f;
  endfunction

  task automatic check(string tag);
    int exp_a;
    exp_a = (m_chap << 10) | (m_page << 6) | m_pc;
    total++;
    if (addr_o !== 11'(exp_a) || in_sub_o !== 1'(m_sub)) begin
      bad++;
      $display("FAIL %s addr=%h sub=%b expected addr=%h sub=%0d", tag, addr_o, in_sub_o, exp_a, m_sub);
    end
  endtask

  task automatic model();
    bit swap, ld;
    int nxt;
    swap = 0;
    ld = pbuf_ld_i;
    nxt = succ(m_pc);
    if (adv_i) begin
      if (ret_i) begin
        if (m_sub == 1) begin
          int t;
          m_pc = m_ret; t = m_page; m_page = m_pbuf; m_pbuf = t; m_sub = 0; swap = 1;
        end else m_pc = nxt;
      end else if (call_i) begin
        if (status_i && m_sub == 0) begin
          int t;
          m_ret = nxt; m_pc = int'(target_i); t = m_page; m_page = m_pbuf; m_pbuf = t;
          m_sub = 1; swap = 1;
        end else m_pc = nxt;
      end else if (branch_i && status_i) begin
        m_pc = int'(target_i);
        if (m_sub == 0) begin m_page = m_pbuf; m_chap = m_cbuf; end
      end else m_pc = nxt;
    end
    if (ld && !swap) begin
      m_pbuf = int'(pbuf_val_i);
      m_cbuf = int'(chap_val_i);
    end
  endtask

  task automatic step(bit a, bit br, bit ca, bit re, bit st, int tg, bit ld, int pv, bit cv, string tag);
    adv_i = a; branch_i = br; call_i = ca; ret_i = re; status_i = st;
    target_i = 6'(tg); pbuf_ld_i = ld; pbuf_val_i = 4'(pv); chap_val_i = cv;
    @(posedge clk_i);
    model();
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen[64];
    int distinct;
    m_pc = 0; m_page = 0; m_pbuf = 0; m_chap = 0; m_cbuf = 0; m_ret = 0; m_sub = 0;
    repeat (3) @(negedge clk_i);
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");

    // R2 full period
    distinct = 0;
    for (int i = 0; i < 64; i++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 step");
      if (!seen[addr_o[5:0]]) begin seen[addr_o[5:0]] = 1; distinct++; end
    end
    total++;
    if (distinct != 64 || addr_o[5:0] != 6'd0) begin
      bad++;
      $display("FAIL R2 period distinct=%0d last=%0d expected distinct=64 last=0", distinct, addr_o[5:0]);
    end

    // R3 requests without advance
    step(0, 1, 0, 0, 1, 21, 0, 0, 0, "R3 branch no adv");
    step(0, 0, 1, 0, 1, 9, 0, 0, 0, "R3 call no adv");
    step(0, 0, 0, 1, 1, 9, 0, 0, 0, "R3 ret no adv");

    // R9 load without advance, then R4
    step(0, 0, 0, 0, 0, 0, 1, 5, 1, "R9 load");
    step(1, 1, 0, 0, 0, 33, 0, 0, 0, "R4 branch not taken");
    step(1, 1, 0, 0, 1, 33, 0, 0, 0, "R4 branch taken");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 layout after far jump");
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, "R8 ret outside sub");

    // R6 / R5 / R7 / R8 / R9
    step(1, 0, 0, 0, 0, 0, 1, 9, 0, "R9 load during step");
    step(1, 0, 1, 0, 0, 12, 0, 0, 0, "R6 call not taken");
    step(1, 0, 1, 0, 1, 12, 0, 0, 0, "R6 call taken");
    step(1, 1, 0, 0, 1, 40, 0, 0, 0, "R5 branch in sub");
    step(1, 0, 1, 0, 1, 7, 0, 0, 0, "R7 call in sub");
    step(1, 0, 0, 1, 0, 0, 1, 14, 1, "R8 ret with load R9 dropped");
    step(1, 1, 0, 0, 1, 2, 0, 0, 0, "R9 buffer after ret");
    step(1, 1, 1, 1, 1, 3, 0, 0, 0, "R8 priority ret");
    step(1, 1, 1, 0, 1, 4, 0, 0, 0, "R8 priority call");
    step(1, 1, 1, 0, 1, 5, 0, 0, 0, "R7 priority in sub");
    step(1, 0, 0, 1, 1, 0, 0, 0, 0, "R8 return");

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0,
           $urandom % 2, $urandom % 64, ($urandom % 3) == 0, $urandom % 16, $urandom % 2,
           "R10 mixed");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule